// File: doc/BRIEF.md
# Performance Counter Unit with Overflow Interrupts

This block keeps three free-running counters for profiling: one counts clock cycles and two count event pulses. Each event counter picks one of 64 single-cycle pulse inputs through a 6-bit selector. A single control word, reached through a simple register port, holds both selectors, a global enable, a divide option for the clock counter, two self-clearing reset strobes, three per-counter interrupt enables and three sticky overflow flags. The flags clear when a 1 is written to them.

Software reads and writes each counter value through the same register port. The port has no back-pressure: a write lands on the clock edge where `reg_wr` is high, and `reg_rdata` shows the addressed register in the same cycle. The block raises one level-sensitive interrupt line while any enabled overflow flag is set.

Top module: `perf_count_unit`

## Requirements
- R1: The control word at address 0 reads back as follows. Bit 0 is the enable, bit 3 the scaler, bits 6:4 the interrupt enables, bits 10:8 the overflow flags, bits 17:12 the selector of event counter 0 and bits 23:18 the selector of event counter 1. Bits 31:24, 11, 7, 2 and 1 always read 0.
- R2: When the enable bit is 0, no counter changes except by a register write. When it is 1 and the scaler is 0, the clock counter adds one every cycle. A write to the enable bit takes effect from the following cycle.
- R3: While enabled, event counter 0 (or 1) adds one in each cycle where the event input selected by its selector is high.
- R4: With the scaler bit set, the clock counter adds one once every PRESCALE enabled cycles. The prescaler restarts whenever the clock counter is reset by a strobe.
- R5: Writing 1 to control bit 2 clears only the clock counter. Writing 1 to bit 1 clears all three counters. A clear beats an increment in the same cycle, and the lost increment sets no flag.
- R6: When a counter wraps from all ones to zero, its flag sets on the same edge. The flags are bit 8 for the clock counter, bit 9 for event counter 0 and bit 10 for event counter 1.
- R7: A flag stays set until a control write puts 1 in its bit. Writing 0 leaves it unchanged. If an overflow and a clear arrive in the same cycle, the overflow wins.
- R8: `irq` is high exactly when some flag is set and its enable is set. Bit 4 enables the clock counter, bit 5 event counter 0 and bit 6 event counter 1.
- R9: Address 1 is the clock counter, 2 is event counter 0 and 3 is event counter 1. A write loads the low CNT_W bits and takes priority over an increment in that cycle. A read returns the value zero-extended.
- R10: After reset, every register and counter is zero and `irq` is low.
- R11: Event inputs not selected by either selector have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 control, 1 clock counter, 2 and 3 event counters) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, same cycle |
| events | input | 64 | Single-cycle event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with CNT_W = 8 and PRESCALE = 4. With these values, wraps of every counter, and the flags they set, occur within a few hundred cycles, and the scaled clock counter visibly advances every fourth cycle. The selector layout stays at full width, so all 64 event inputs stay addressable. A random phase mixes control writes, reset strobes, flag clears and counter loads close to all ones with random event traffic. This drives clear-versus-increment and set-versus-clear collisions against the cycle model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int REG_W     = 32;
  localparam int EVT_NUM   = 64;
  localparam int SEL_W     = 6;
  localparam int NUM_CTR   = 3;
  localparam int SEL1_LO   = 18;
  localparam int SEL0_LO   = 12;
  localparam int FLAG_LO   = 8;
  localparam int IE_LO     = 4;
  localparam int SCALE_BIT = 3;
  localparam int CRST_BIT  = 2;
  localparam int ARST_BIT  = 1;
  localparam int EN_BIT    = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CYC  = 2'd1,
    ADDR_EV0  = 2'd2,
    ADDR_EV1  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0]   sel1;
    logic [SEL_W-1:0]   sel0;
    logic [NUM_CTR-1:0] ie;
    logic               scale;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/pcu_ctrl_reg.sv
module pcu_ctrl_reg
  import pcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_CTR-1:0] ovf,
  output ctrl_t              ctrl,
  output logic [NUM_CTR-1:0] flags,
  output logic               clr_cyc,
  output logic               clr_all,
  output logic [REG_W-1:0]   rd_ctrl
);
  logic [NUM_CTR-1:0] w1c_mask;
  logic               unused_bits;

  assign unused_bits = ^{wdata[31:24], wdata[11], wdata[7]};
  assign w1c_mask = wr_ctrl ? wdata[FLAG_LO +: NUM_CTR] : '0;
  assign clr_cyc  = wr_ctrl & wdata[CRST_BIT];
  assign clr_all  = wr_ctrl & wdata[ARST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      flags <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.sel1  <= wdata[SEL1_LO +: SEL_W];
        ctrl.sel0  <= wdata[SEL0_LO +: SEL_W];
        ctrl.ie    <= wdata[IE_LO +: NUM_CTR];
        ctrl.scale <= wdata[SCALE_BIT];
        ctrl.en    <= wdata[EN_BIT];
      end
      flags <= (flags & ~w1c_mask) | ovf;
    end
  end

  always_comb begin
    rd_ctrl = '0;
    rd_ctrl[SEL1_LO +: SEL_W]    = ctrl.sel1;
    rd_ctrl[SEL0_LO +: SEL_W]    = ctrl.sel0;
    rd_ctrl[FLAG_LO +: NUM_CTR]  = flags;
    rd_ctrl[IE_LO +: NUM_CTR]    = ctrl.ie;
    rd_ctrl[SCALE_BIT]           = ctrl.scale;
    rd_ctrl[EN_BIT]              = ctrl.en;
  end
endmodule

// File: rtl/pcu_prescaler.sv
module pcu_prescaler #(
  parameter int PRESCALE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clear) begin
      phase <= '0;
    end else if (run) begin
      phase <= tick ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         ovf
);
  assign ovf = inc & ~clear & ~load & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clear) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (inc) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [EVT_NUM-1:0] events,
  output logic               irq
);
  ctrl_t                          ctrl;
  logic [NUM_CTR-1:0]             flags;
  logic [NUM_CTR-1:0]             ovf;
  logic [NUM_CTR-1:0]             inc_vec;
  logic [NUM_CTR-1:0]             clr_vec;
  logic [NUM_CTR-1:0]             load_vec;
  logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]               rd_ctrl;
  logic                           clr_cyc;
  logic                           clr_all;
  logic                           tick;
  logic                           wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  pcu_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (reg_wdata),
    .ovf     (ovf),
    .ctrl    (ctrl),
    .flags   (flags),
    .clr_cyc (clr_cyc),
    .clr_all (clr_all),
    .rd_ctrl (rd_ctrl)
  );

  pcu_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr_cyc | clr_all),
    .run   (ctrl.en & ctrl.scale),
    .tick  (tick)
  );

  assign inc_vec[0] = ctrl.en & (~ctrl.scale | tick);
  assign inc_vec[1] = ctrl.en & events[ctrl.sel0];
  assign inc_vec[2] = ctrl.en & events[ctrl.sel1];
  assign clr_vec    = {clr_all, clr_all, clr_all | clr_cyc};

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    assign load_vec[k] = reg_wr && (reg_addr == 2'(k + 1));
    pcu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clr_vec[k]),
      .load     (load_vec[k]),
      .load_val (reg_wdata[CNT_W-1:0]),
      .inc      (inc_vec[k]),
      .value    (cnt_q[k]),
      .ovf      (ovf[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = rd_ctrl;
      ADDR_CYC:  reg_rdata[CNT_W-1:0] = cnt_q[0];
      ADDR_EV0:  reg_rdata[CNT_W-1:0] = cnt_q[1];
      default:   reg_rdata[CNT_W-1:0] = cnt_q[2];
    endcase
  end

  assign irq = |(flags & ctrl.ie);
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [1:0]            reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [31:0]           reg_rdata,
  input logic                  irq,
  input logic                  en,
  input logic                  scale,
  input logic                  tick,
  input logic [2:0]            ie,
  input logic [2:0]            flags,
  input logic [2:0][CNT_W-1:0] cnt_q
);
  logic       ctl_wr;
  logic [2:0] clr_mask;

  assign ctl_wr   = reg_wr && (reg_addr == 2'd0);
  assign clr_mask = ctl_wr ? reg_wdata[10:8] : 3'b000;

  assert_ctrl_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[31:24] == 8'd0 && !reg_rdata[11] && !reg_rdata[7]
                            && reg_rdata[2:1] == 2'b00));

  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_wr) |=> $stable(cnt_q));

  assert_scaler_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scale && !tick && !reg_wr) |=> $stable(cnt_q[0]));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1]) |=> (cnt_q == '0));

  assert_clear_cyc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[2]) |=> (cnt_q[0] == '0));

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !scale && (&cnt_q[0]) && !reg_wr) |=> (flags[0] && cnt_q[0] == '0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == 3'b000));

  assert_irq_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 3'b000 || flags == 3'b000) |-> !irq);
endmodule

bind perf_count_unit pcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .en        (ctrl.en),
  .scale     (ctrl.scale),
  .tick      (tick),
  .ie        (ctrl.ie),
  .flags     (flags),
  .cnt_q     (cnt_q)
);

// File: tb/perf_count_unit_test.sv
`timescale 1ns/100ps
module perf_count_unit_test;
  localparam int  CW   = 8;
  localparam int  PS   = 4;
  localparam longint MASK = (longint'(1) << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] events = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_count_unit #(.CNT_W(CW), .PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .irq(irq)
  );

  // Behavioural reference model
  longint m_cnt [3];
  int     m_pre;
  bit     m_flag [3];
  bit     m_ie [3];
  bit     m_en, m_scale;
  int     m_sel0, m_sel1;

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 2'd0) begin
      v[23:18] = 6'(m_sel1); v[17:12] = 6'(m_sel0);
      v[8] = m_flag[0]; v[9] = m_flag[1]; v[10] = m_flag[2];
      v[4] = m_ie[0]; v[5] = m_ie[1]; v[6] = m_ie[2];
      v[3] = m_scale; v[0] = m_en;
    end else begin
      v = 32'(m_cnt[a - 1]);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_cnt[k] = 0; m_flag[k] = 0; m_ie[k] = 0;
      end
      m_pre = 0; m_en = 0; m_scale = 0; m_sel0 = 0; m_sel1 = 0;
    end else begin
      bit cw, ca, cc;
      bit inc [3];
      cw = reg_wr && reg_addr == 2'd0;
      cc = cw && reg_wdata[2];
      ca = cw && reg_wdata[1];
      inc[0] = m_en && (!m_scale || m_pre == PS - 1);
      inc[1] = m_en && events[m_sel0];
      inc[2] = m_en && events[m_sel1];
      for (int k = 0; k < 3; k++) begin
        bit clr, ld, ov;
        clr = ca || (k == 0 && cc);
        ld  = reg_wr && reg_addr == 2'(k + 1);
        ov  = !clr && !ld && inc[k] && m_cnt[k] == MASK;
        if (clr) m_cnt[k] = 0;
        else if (ld) m_cnt[k] = longint'(reg_wdata) & MASK;
        else if (inc[k]) m_cnt[k] = (m_cnt[k] + 1) & MASK;
        if (cw && reg_wdata[8 + k]) m_flag[k] = 0;
        if (ov) m_flag[k] = 1;
      end
      if (cc || ca) m_pre = 0;
      else if (m_en && m_scale) m_pre = (m_pre == PS - 1) ? 0 : m_pre + 1;
      if (cw) begin
        m_sel1 = int'(reg_wdata[23:18]); m_sel0 = int'(reg_wdata[17:12]);
        for (int k = 0; k < 3; k++) m_ie[k] = reg_wdata[4 + k];
        m_scale = reg_wdata[3]; m_en = reg_wdata[0];
      end
    end
  end

  // Per-cycle comparison against the model (R8 irq, R9 read data)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] e;
      logic ei;
      #1.8;
      e  = model_rd(reg_addr);
      ei = (m_flag[0] & m_ie[0]) | (m_flag[1] & m_ie[1]) | (m_flag[2] & m_ie[2]);
      checks++;
      if (reg_rdata !== e) begin
        failures++;
        $display("FAIL R9 model rdata addr=%0d actual=%h expected=%h", reg_addr, reg_rdata, e);
      end
      checks++;
      if (irq !== ei) begin
        failures++;
        $display("FAIL R8 model irq actual=%b expected=%b", irq, ei);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [63:0] v);
    events = v;
    @(negedge clk);
    events = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(2'd0, 32'h0, "R10 ctrl after reset");
    rd(2'd1, 32'h0, "R10 clock counter after reset");
    rd(2'd2, 32'h0, "R10 event counter 0 after reset");
    rd(2'd3, 32'h0, "R10 event counter 1 after reset");
    chk("R10 irq after reset", 32'(irq), 32'h0);

    // R1 layout and zero bits
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, 32'h00FF_F078, "R1 ctrl readback");
    chk("R8 irq with enables but no flags", 32'(irq), 32'h0);

    // R9 counter load and width
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_01F5);
    rd(2'd1, 32'h0000_00F5, "R9 clock counter load truncated");
    wr(2'd2, 32'h0000_0ABC);
    rd(2'd2, 32'h0000_00BC, "R9 event counter 0 load");
    wr(2'd2, 32'h0);

    // R2 disabled holds, enabled counts
    idle(5);
    rd(2'd1, 32'h0000_00F5, "R2 clock counter holds while disabled");
    wr(2'd0, 32'h1);
    rd(2'd1, 32'h0000_00F5, "R2 enable takes effect next cycle");
    idle(5);
    rd(2'd1, 32'h0000_00FA, "R2 clock counter counts every cycle");
    idle(6);
    rd(2'd1, 32'h0, "R6 clock counter wrapped");
    rd(2'd0, 32'h0000_0101, "R6 clock flag set on wrap");
    chk("R8 irq low with flag but no enable", 32'(irq), 32'h0);

    // R8 irq and R7 clear
    wr(2'd0, 32'h11);
    chk("R8 irq with flag and enable", 32'(irq), 32'h1);
    wr(2'd0, 32'h110);
    chk("R7 irq after flag clear", 32'(irq), 32'h0);
    rd(2'd0, 32'h0000_0010, "R7 flag cleared by writing 1");

    // R3 and R11 event selection
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h0024_5001);
    pulse(64'h20); pulse(64'h20); pulse(64'h20);
    pulse(64'h80); pulse(64'h80);
    pulse(64'h200);
    pulse(64'h220);
    rd(2'd2, 32'h4, "R3 event counter 0 count");
    rd(2'd3, 32'h2, "R3 event counter 1 count");
    pulse(64'hFFFF_FFFF_FFFF_FDDF);
    rd(2'd2, 32'h4, "R11 unselected events ignored counter 0");
    rd(2'd3, 32'h2, "R11 unselected events ignored counter 1");

    // R6 and R7 event overflow flag
    wr(2'd2, 32'hFF);
    pulse(64'h20);
    rd(2'd2, 32'h0, "R6 event counter 0 wrapped");
    rd(2'd0, 32'h0024_5201, "R6 event counter 0 flag bit 9");
    wr(2'd0, 32'h0024_5001);
    rd(2'd0, 32'h0024_5201, "R7 writing 0 keeps flag");
    wr(2'd0, 32'h0024_5201);
    rd(2'd0, 32'h0024_5001, "R7 writing 1 clears flag");

    // R5 reset strobes
    wr(2'd0, 32'h0024_5005);
    rd(2'd1, 32'h0, "R5 clock counter strobe");
    rd(2'd3, 32'h2, "R5 clock strobe leaves event counter");
    wr(2'd0, 32'h0024_5003);
    rd(2'd3, 32'h0, "R5 all-counter strobe");
    rd(2'd0, 32'h0024_5001, "R1 strobe bits read zero");

    // R4 scaler
    wr(2'd0, 32'h0000_000D);
    rd(2'd1, 32'h0, "R4 clock counter cleared");
    idle(3);
    rd(2'd1, 32'h0, "R4 no increment before period");
    idle(1);
    rd(2'd1, 32'h1, "R4 one increment per period");
    idle(4);
    rd(2'd1, 32'h2, "R4 second increment");

    // R5 clear beats wrap
    wr(2'd0, 32'h1);
    wr(2'd1, 32'hFF);
    wr(2'd0, 32'h5);
    rd(2'd1, 32'h0, "R5 clear wins over increment");
    rd(2'd0, 32'h1, "R5 no flag from lost wrap");

    // Random phase, compared with the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] d;
      r = int'($urandom % 16);
      events = {$urandom, $urandom} & 64'hFF00_0000_0000_00FF;
      if (r == 0) begin
        d = $urandom & 32'hFFFF_FFF9;
        d[23:18] = 6'($urandom % 8);
        d[17:12] = 6'($urandom % 8);
        d[0] = ($urandom % 4) != 0;
        d[2] = ($urandom % 4) == 0;
        d[1] = ($urandom % 16) == 0;
        wr(2'd0, d);
      end else if (r < 3) begin
        wr(2'(1 + $urandom % 3), 32'hF0 + ($urandom % 16));
      end else begin
        reg_addr = 2'($urandom % 4);
        @(negedge clk);
      end
    end
    events = '0;
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule